// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full and Programmable Edge Flag

This block is an 18-bit, 2048-deep first-in first-out buffer. Its write side and its read side each run on their own free-running clock. Each domain keeps a binary pointer and a Gray copy of it. The Gray copy crosses into the other domain through two flip-flops. Full and empty are judged from these delayed copies, so both can only be reported late, never early.

The write side reports `in_ready` while there is room. It also reports two occupancy flags from a count held in the write domain:
- `half_full`.
- A single edge flag, `edge_flag`. It is high when the buffer is nearly empty or nearly full.

The distance from either end is a 10-bit offset. The offset is loaded from the low data bits when the `offset_load_n` strobe falls. It takes effect through a reset held with the strobe low. If the strobe is high during reset, the offset returns to 256.

The read side presents the oldest word on `dout` without any request and raises `out_ready`. Further words are consumed when the read enables and the output enable are all high. A low `out_en` forces `dout` to zero and blocks consumption.

Top module: `dual_clock_fifo`

## Requirements
- R1: A word on `din` is stored at a rising `wr_clk` edge only when `in_ready`, `wr_en_a` and `wr_en_b` are all high. Stored words leave in the order they were accepted. Any other write attempt is dropped.
- R2: The presented word is consumed at a rising `rd_clk` edge only when `out_ready`, `out_en`, `rd_en_a` and `rd_en_b` are all high. Otherwise `dout` and `out_ready` hold.
- R3: When `out_en` is low, `dout` is all zeros.
- R4: When the buffer is empty and a word is written at a `wr_clk` edge, the word appears on `dout` at the third rising `rd_clk` edge after that write edge. `out_ready` rises at that same edge. The read enables have no effect on this.
- R5: `out_ready` falls at the `rd_clk` edge that consumes the last word.
- R6: With no reads, `in_ready` falls after 2049 accepted words: 2048 in storage plus the one presented on `dout`.
- R7: `half_full` is high exactly when the stored count is 1024 or more, once the count has settled. The stored count excludes the word presented on `dout`.
- R8: `edge_flag` is high exactly when the settled stored count is at most X or at least 2048 − X.
- R9: The `wr_clk` domain samples `offset_load_n`. On a sampled falling edge of the strobe, `din[9:0]` is captured as a pending offset; the write enables play no part in this. A reset with the strobe low makes the pending offset X. Later resets with the strobe still low keep it. A reset with the strobe high sets X to 256.
- R10: After `rst_n` has been low for at least four cycles of each clock, `in_ready`, `out_ready` and `half_full` are low, `edge_flag` is high, and all contents are discarded.
- R11: `in_ready` goes low at the second `wr_clk` edge after `rst_n` goes low. It goes high at the second `wr_clk` edge after `rst_n` returns high. After a full condition, it returns high once words are read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, synchronized into each domain |
| din | input | 18 | Write data; bits 9..0 also carry the offset value |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| offset_load_n | input | 1 | Offset strobe: its fall captures the offset, its level during reset selects stored or default |
| in_ready | output | 1 | Space available (write domain) |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output gate; also needed for a read |
| dout | output | 18 | Presented word, zero while out_en is low |
| out_ready | output | 1 | A word is presented (read domain) |
| half_full | output | 1 | Stored count at least half the depth |
| edge_flag | output | 1 | Stored count within X of empty or of full |

## Verification
The fall-through result is due at the third `rd_clk` rise after the write edge. The bench therefore counts read-clock edges from that write edge and samples one time unit after the second and the third. `in_ready` follows `rst_n` two write edges later, and the bench samples it at the write-clock falling edges in between. The occupancy flags move with cross-domain lag, so each flag check first waits ten write cycles after the last write for the count to settle. Data order is checked by a scoreboard. The monitor compares the presented word at each read-clock falling edge, before the rising edge at which it requests the next word.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int W         = 18,
  parameter int DEPTH     = 2048,
  parameter int XW        = 10,
  parameter int X_DEFAULT = 256
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         wr_en_a,
  input  logic         wr_en_b,
  input  logic         offset_load_n,
  output logic         in_ready,
  input  logic         rd_en_a,
  input  logic         rd_en_b,
  input  logic         out_en,
  output logic [W-1:0] dout,
  output logic         out_ready,
  output logic         half_full,
  output logic         edge_flag
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];

  // write domain
  logic [1:0]    wsync;
  logic          wrun;
  logic [PW-1:0] wbin, wgray, rg_w1, rg_w2, wcount;
  logic [XW-1:0] x_pend, x_act;
  logic          strobe_q, full, push;

  always_ff @(posedge wr_clk) wsync <= {wsync[0], rst_n};
  assign wrun   = wsync[1];
  assign wcount = wbin - from_gray(rg_w2);
  assign full   = (wcount == PW'(DEPTH));
  assign in_ready = wrun & ~full;
  assign push   = in_ready & wr_en_a & wr_en_b;

  always_ff @(posedge wr_clk) begin
    strobe_q <= offset_load_n;
    if (strobe_q && !offset_load_n) x_pend <= din[XW-1:0];
  end

  always_ff @(posedge wr_clk) begin
    if (!wrun) begin
      wbin      <= '0;
      wgray     <= '0;
      rg_w1     <= '0;
      rg_w2     <= '0;
      half_full <= 1'b0;
      edge_flag <= 1'b1;
      x_act     <= offset_load_n ? XW'(X_DEFAULT) : x_pend;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (push) begin
        wbin  <= wbin + PW'(1);
        wgray <= to_gray(wbin + PW'(1));
      end
      half_full <= (wcount >= PW'(HALF));
      edge_flag <= (wcount <= PW'(x_act)) || (wcount >= PW'(DEPTH) - PW'(x_act));
    end
  end

  always_ff @(posedge wr_clk)
    if (push) mem[wbin[AW-1:0]] <= din;

  // read domain
  logic [1:0]    rsync;
  logic          rrun;
  logic [PW-1:0] rbin, rgray, wg_r1, wg_r2;
  logic [W-1:0]  q_reg;
  logic          empty, take, load;

  always_ff @(posedge rd_clk) rsync <= {rsync[0], rst_n};
  assign rrun  = rsync[1];
  assign empty = (rgray == wg_r2);
  assign take  = out_ready & out_en & rd_en_a & rd_en_b;
  assign load  = rrun & ~empty & (~out_ready | take);

  always_ff @(posedge rd_clk) begin
    if (!rrun) begin
      rbin      <= '0;
      rgray     <= '0;
      wg_r1     <= '0;
      wg_r2     <= '0;
      out_ready <= 1'b0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (load) begin
        rbin      <= rbin + PW'(1);
        rgray     <= to_gray(rbin + PW'(1));
        out_ready <= 1'b1;
      end else if (take) begin
        out_ready <= 1'b0;
      end
    end
  end

  always_ff @(posedge rd_clk)
    if (load) q_reg <= mem[rbin[AW-1:0]];

  assign dout = out_en ? q_reg : '0;

  // R1
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wrun)
    wcount <= PW'(DEPTH));

  // R2
  hold_word_chk: assert property (@(posedge rd_clk) disable iff (!rrun)
    (out_ready && !take) |=> $stable(q_reg));

  // R5
  ready_fall_chk: assert property (@(posedge rd_clk) disable iff (!rrun)
    $fell(out_ready) |-> $past(take));

  // R10
  reset_flags_chk: assert property (@(posedge wr_clk)
    !wrun |=> (edge_flag && !half_full));
endmodule

// File: tb/tb_dual_clock_fifo.sv
module tb_dual_clock_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_HALF    = 7;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [17:0] din = '0;
  logic wr_en_a = 0, wr_en_b = 0, offset_load_n = 1;
  logic rd_en_a = 0, rd_en_b = 0, out_en = 1;
  logic in_ready, out_ready, half_full, edge_flag;
  logic [17:0] dout;

  dual_clock_fifo dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .offset_load_n(offset_load_n),
    .in_ready(in_ready), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .out_en(out_en), .dout(dout), .out_ready(out_ready),
    .half_full(half_full), .edge_flag(edge_flag));

  initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin #3; forever #RD_HALF rd_clk = ~rd_clk; end

  int checks = 0, errors = 0;
  logic [17:0] sb[$];
  logic mon_on = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge rd_clk);
    if (mon_on) begin
      if (out_ready && out_en) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R1: actual %0h expected no word", dout);
        end else begin
          logic [17:0] e;
          e = sb.pop_front();
          if (dout != e) begin
            errors++;
            $display("FAIL R1: actual %0h expected %0h", dout, e);
          end
        end
        rd_en_a = 1; rd_en_b = 1;
      end else begin
        rd_en_a = 0; rd_en_b = 0;
      end
    end
  end

  task automatic do_reset(input logic strobe);
    @(negedge wr_clk);
    offset_load_n = strobe;
    rst_n = 0;
    repeat (8) @(negedge wr_clk);
    sb.delete();
    rst_n = 1;
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic write_word(input logic [17:0] d, input logic a, input logic b, output logic acc);
    @(negedge wr_clk);
    din = d; wr_en_a = a; wr_en_b = b;
    acc = in_ready & a & b;
    if (acc) sb.push_back(d);
    @(posedge wr_clk);
  endtask

  task automatic settle();
    @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 0;
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic write_n(input int n);
    logic acc;
    for (int i = 0; i < n; i++) write_word(18'(i * 7 + 3), 1, 1, acc);
    settle();
  endtask

  task automatic drain();
    mon_on = 1;
    for (int i = 0; i < 20000 && (sb.size() != 0 || out_ready); i++) @(negedge rd_clk);
    mon_on = 0;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic acc;
    int n;
    do_reset(1);
    // R10 reset state
    check("R10 in_ready", in_ready, 1);
    check("R10 edge_flag", edge_flag, 1);
    // R11 in_ready timing around reset
    @(negedge wr_clk); rst_n = 0;
    @(negedge wr_clk); check("R11 one edge into reset", in_ready, 1);
    @(negedge wr_clk); check("R11 second edge into reset", in_ready, 0);
    repeat (6) @(negedge wr_clk);
    check("R10 half_full", half_full, 0);
    check("R10 edge_flag", edge_flag, 1);
    check("R10 out_ready", out_ready, 0);
    rst_n = 1;
    @(negedge wr_clk); check("R11 one edge after release", in_ready, 0);
    @(negedge wr_clk); check("R11 second edge after release", in_ready, 1);
    repeat (4) @(negedge wr_clk);

    // R4 fall-through latency
    @(negedge wr_clk);
    din = 18'h2A5A5; wr_en_a = 1; wr_en_b = 1;
    @(posedge wr_clk);
    fork begin @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0; end join_none
    @(posedge rd_clk); @(posedge rd_clk); #1;
    check("R4 not yet at second edge", out_ready, 0);
    @(posedge rd_clk); #1;
    check("R4 out_ready at third edge", out_ready, 1);
    check("R4 word at third edge", dout, 18'h2A5A5);

    // R3 and R2: gate low blocks output and consumption
    @(negedge rd_clk); out_en = 0; rd_en_a = 1; rd_en_b = 1;
    repeat (4) @(negedge rd_clk);
    check("R3 dout zero while gated", dout, 0);
    check("R2 no read while gated", out_ready, 1);
    out_en = 1; rd_en_b = 0;
    repeat (3) @(negedge rd_clk);
    check("R2 one enable low holds word", dout, 18'h2A5A5);
    check("R2 one enable low holds ready", out_ready, 1);
    rd_en_b = 1;
    @(negedge rd_clk); rd_en_a = 0; rd_en_b = 0;
    check("R5 out_ready falls after last read", out_ready, 0);

    // R1 scoreboard stream with mixed patterns and dropped attempts
    do_reset(1);
    mon_on = 1;
    for (int i = 0; i < 300; i++) begin
      logic [17:0] d;
      d = (i % 3 == 0) ? 18'(i) : (i % 3 == 1) ? 18'h15555 ^ 18'(i) : 18'($urandom);
      write_word(d, (i % 11) != 5, (i % 13) != 7, acc);
    end
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    drain();
    check("R1 all accepted words delivered", sb.size(), 0);

    // R6 R7 R8 fill with default offset
    do_reset(1);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      write_word(18'(i), 1, 1, acc);
      if (!acc) break;
      n++;
      if (n == 257)  begin settle(); check("R8 count 256 low edge", edge_flag, 1); end
      if (n == 258)  begin settle(); check("R8 count 257 mid", edge_flag, 0); end
      if (n == 1024) begin settle(); check("R7 count 1023", half_full, 0); end
      if (n == 1025) begin settle(); check("R7 count 1024", half_full, 1); end
      if (n == 1792) begin settle(); check("R8 count 1791 mid", edge_flag, 0); end
      if (n == 1793) begin settle(); check("R8 count 1792 high edge", edge_flag, 1); end
    end
    settle();
    check("R6 capacity", n, 2049);
    check("R11 in_ready low when full", in_ready, 0);
    write_word(18'h3FFFF, 1, 1, acc);
    check("R1 write dropped when full", acc, 0);
    @(negedge wr_clk); wr_en_a = 0; wr_en_b = 0;
    mon_on = 1;
    repeat (20) @(negedge wr_clk);
    check("R11 in_ready back after reads", in_ready, 1);
    drain();
    check("R1 fill contents in order", sb.size(), 0);

    // R9 programmed offset
    @(negedge wr_clk); offset_load_n = 1; din = 18'h3F000 | 18'd100;
    @(negedge wr_clk); offset_load_n = 0;
    @(negedge wr_clk); din = 18'h00123;
    do_reset(0);
    write_n(101);
    check("R9 programmed X count 100", edge_flag, 1);
    write_n(1);
    check("R9 programmed X count 101", edge_flag, 0);
    do_reset(0);
    write_n(102);
    check("R9 X kept over reset", edge_flag, 0);
    do_reset(1);
    write_n(102);
    check("R9 default X restored", edge_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule